// File: doc/BRIEF.md
# Dual-Core GPIO Pin Ownership Multiplexer

This block sits between one GPIO port of up to eight pins and two processor cores. Each pin has an owner bit. A pin owned by the primary core takes its output value and output enable from the primary core's own selection chain. A pin owned by the secondary core passes that core's output and enable straight to the pad. On the primary side each pin can run as plain software-driven GPIO or as a peripheral pin. A peripheral pin draws from one of up to sixteen peripherals, taken either from a standard bank or from an alternate bank. Pad input levels go unmodified to the secondary core. The primary core sees them only on pins whose digital enable is set, whoever owns the pin.

The primary core configures everything through a small synchronous register bus with a word address, a write strobe and combinational read data. At reset the ownership register loads a build-time mask. Pins in the mask start under the secondary core and every other pin starts under the primary core.

Top module: `gpio_own_mux`

## Requirements
- R1: After reset the ownership register reads back as the parameter SEC_MASK (default 8'hC0), and the output value, direction, peripheral-enable, alternate-enable, digital-enable and both selector registers read 0.
- R2: A pin whose ownership bit is 1 drives pad_out and pad_oe from sec_out and sec_oe of that pin. A pin whose bit is 0 drives them from the primary-core path.
- R3: On a primary-owned, digitally enabled pin with its peripheral-enable bit clear, pad_out equals the output-value register bit and pad_oe equals the direction register bit.
- R4: On a primary-owned pin with peripheral enable set and alternate enable clear, the 4-bit standard selector field at bits [4i+3:4i] of register 7 picks peripheral p. pad_out and pad_oe then equal std_pout and std_poe bit p*NPINS+i.
- R5: With alternate enable also set, the alternate selector field at bits [4i+3:4i] of register 8 picks peripheral p from alt_pout and alt_poe bit p*NPINS+i, and the standard bank is ignored for that pin.
- R6: On a primary-owned pin with digital enable clear, pad_oe is 0, and that pin reads 0 in pri_in and in the pin-level register.
- R7: When a pin's digital-enable bit is set, pri_in and the pin-level register (address 1) show its pad_in level even if the secondary core owns it.
- R8: sec_in always equals pad_in, regardless of ownership and digital enable.
- R9: A write takes effect at the next rising clock edge, not before. Register addresses are 0 output value, 1 pin level (read-only, writes ignored), 2 direction, 3 peripheral enable, 4 alternate enable, 5 digital enable, 6 ownership, 7 standard selectors, 8 alternate selectors. Other addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| std_pout | input | NPERIPH*NPINS | Standard-bank peripheral outputs, bit p*NPINS+i |
| std_poe | input | NPERIPH*NPINS | Standard-bank peripheral output enables |
| alt_pout | input | NPERIPH*NPINS | Alternate-bank peripheral outputs |
| alt_poe | input | NPERIPH*NPINS | Alternate-bank peripheral output enables |
| pri_in | output | NPINS | Pad levels seen by the primary core (gated by digital enable) |
| sec_out | input | NPINS | Secondary core output values |
| sec_oe | input | NPINS | Secondary core output enables |
| sec_in | output | NPINS | Raw pad levels to the secondary core |
| pad_in | input | NPINS | Levels from the pads |
| pad_out | output | NPINS | Output values to the pads |
| pad_oe | output | NPINS | Output enables to the pads |

## Verification
The hardest case to reach from the ports is an alternate-bank selection that differs from a still-live standard-bank selection on the same pin. The bench has to show that the alternate path wins and that the standard path is really ignored. It programs both selector fields to different peripherals and drives a level only on the standard candidate first, then only on the alternate one, then on an alternate peripheral that the field does not name. A second hard case is a pin under the secondary core that the primary core still reads. The bench hands a pin to the secondary core and then toggles its digital enable. It watches the pin-level register follow pad_in while sec_in stays raw.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;

    localparam int SEL_W  = 4;
    localparam int WORD_W = 32;

    typedef enum logic [3:0] {
        A_DOUT   = 4'd0,
        A_PIN    = 4'd1,
        A_DIR    = 4'd2,
        A_PFEN   = 4'd3,
        A_ALTEN  = 4'd4,
        A_DEN    = 4'd5,
        A_OWNER  = 4'd6,
        A_STDSEL = 4'd7,
        A_ALTSEL = 4'd8
    } reg_addr_e;

    // Per-pin configuration slice taken from the register file
    typedef struct packed {
        logic             dout;
        logic             dir;
        logic             pfen;
        logic             alten;
        logic             den;
        logic             owner;
        logic [SEL_W-1:0] std_sel;
        logic [SEL_W-1:0] alt_sel;
    } pin_cfg_t;

    // Output value plus enable for one pin
    typedef struct packed {
        logic val;
        logic oe;
    } drive_t;

    function automatic logic [SEL_W-1:0] field_of(input logic [WORD_W-1:0] v, input int idx);
        return v[idx*SEL_W +: SEL_W];
    endfunction

endpackage

// File: rtl/gpio_own_regs.sv
module gpio_own_regs
    import gpio_own_pkg::*;
#(
    parameter int                NPINS    = 8,
    parameter logic [NPINS-1:0]  SEC_MASK = '0
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [3:0]             bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    output logic [WORD_W-1:0]      bus_rdata,
    input  logic [NPINS-1:0]       pin_level,
    output pin_cfg_t [NPINS-1:0]   cfg
);

    localparam int FW = NPINS * SEL_W;

    logic [NPINS-1:0] dout_q, dir_q, pfen_q, alten_q, den_q, owner_q;
    logic [FW-1:0]    std_q, alt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q  <= '0;
            dir_q   <= '0;
            pfen_q  <= '0;
            alten_q <= '0;
            den_q   <= '0;
            owner_q <= SEC_MASK;
            std_q   <= '0;
            alt_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DOUT:   dout_q  <= bus_wdata[NPINS-1:0];
                A_DIR:    dir_q   <= bus_wdata[NPINS-1:0];
                A_PFEN:   pfen_q  <= bus_wdata[NPINS-1:0];
                A_ALTEN:  alten_q <= bus_wdata[NPINS-1:0];
                A_DEN:    den_q   <= bus_wdata[NPINS-1:0];
                A_OWNER:  owner_q <= bus_wdata[NPINS-1:0];
                A_STDSEL: std_q   <= bus_wdata[FW-1:0];
                A_ALTSEL: alt_q   <= bus_wdata[FW-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DOUT:   bus_rdata[NPINS-1:0] = dout_q;
            A_PIN:    bus_rdata[NPINS-1:0] = pin_level;
            A_DIR:    bus_rdata[NPINS-1:0] = dir_q;
            A_PFEN:   bus_rdata[NPINS-1:0] = pfen_q;
            A_ALTEN:  bus_rdata[NPINS-1:0] = alten_q;
            A_DEN:    bus_rdata[NPINS-1:0] = den_q;
            A_OWNER:  bus_rdata[NPINS-1:0] = owner_q;
            A_STDSEL: bus_rdata[FW-1:0]    = std_q;
            A_ALTSEL: bus_rdata[FW-1:0]    = alt_q;
            default:  bus_rdata = '0;
        endcase
    end

    logic [WORD_W-1:0] std_word, alt_word;
    always_comb begin
        std_word = '0;
        alt_word = '0;
        std_word[FW-1:0] = std_q;
        alt_word[FW-1:0] = alt_q;
        for (int i = 0; i < NPINS; i++) begin
            cfg[i].dout    = dout_q[i];
            cfg[i].dir     = dir_q[i];
            cfg[i].pfen    = pfen_q[i];
            cfg[i].alten   = alten_q[i];
            cfg[i].den     = den_q[i];
            cfg[i].owner   = owner_q[i];
            cfg[i].std_sel = field_of(std_word, i);
            cfg[i].alt_sel = field_of(alt_word, i);
        end
    end

    AST_OWNER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> owner_q == SEC_MASK);                              // R1
    AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_OWNER) |=> owner_q == $past(bus_wdata[NPINS-1:0])); // R9
    AST_PIN_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_PIN) |=> $stable(dout_q) && $stable(den_q)); // R9

endmodule

// File: rtl/gpio_own_pinmux.sv
module gpio_own_pinmux
    import gpio_own_pkg::*;
#(
    parameter int NPERIPH = 16
) (
    input  pin_cfg_t           cfg,
    input  logic [NPERIPH-1:0] std_out,
    input  logic [NPERIPH-1:0] std_oe,
    input  logic [NPERIPH-1:0] alt_out,
    input  logic [NPERIPH-1:0] alt_oe,
    output drive_t             pri
);

    logic [SEL_W-1:0] sel;
    drive_t           periph;

    assign sel = cfg.alten ? cfg.alt_sel : cfg.std_sel;

    // Selector values beyond NPERIPH leave the peripheral drive at zero
    always_comb begin
        periph = '0;
        for (int p = 0; p < NPERIPH; p++) begin
            if (sel == SEL_W'(p)) begin
                periph.val = cfg.alten ? alt_out[p] : std_out[p];
                periph.oe  = cfg.alten ? alt_oe[p]  : std_oe[p];
            end
        end
    end

    always_comb begin
        if (cfg.pfen) begin
            pri = periph;
        end else begin
            pri.val = cfg.dout;
            pri.oe  = cfg.dir;
        end
    end

endmodule

// File: rtl/gpio_own_route.sv
module gpio_own_route
    import gpio_own_pkg::*;
#(
    parameter int NPINS = 8
) (
    input  pin_cfg_t [NPINS-1:0] cfg,
    input  drive_t   [NPINS-1:0] pri,
    input  logic [NPINS-1:0]     sec_out,
    input  logic [NPINS-1:0]     sec_oe,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [NPINS-1:0]     pri_in,
    output logic [NPINS-1:0]     sec_in
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            if (cfg[i].owner) begin
                pad_out[i] = sec_out[i];
                pad_oe[i]  = sec_oe[i];
            end else begin
                pad_out[i] = pri[i].val;
                pad_oe[i]  = pri[i].oe & cfg[i].den;
            end
            pri_in[i] = pad_in[i] & cfg[i].den;
            sec_in[i] = pad_in[i];
        end
    end

endmodule

// File: rtl/gpio_own_mux.sv
module gpio_own_mux
    import gpio_own_pkg::*;
#(
    parameter int               NPINS    = 8,
    parameter int               NPERIPH  = 16,
    parameter logic [NPINS-1:0] SEC_MASK = 8'hC0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_wr,
    input  logic [3:0]                 bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NPERIPH*NPINS-1:0]   std_pout,
    input  logic [NPERIPH*NPINS-1:0]   std_poe,
    input  logic [NPERIPH*NPINS-1:0]   alt_pout,
    input  logic [NPERIPH*NPINS-1:0]   alt_poe,
    output logic [NPINS-1:0]           pri_in,
    input  logic [NPINS-1:0]           sec_out,
    input  logic [NPINS-1:0]           sec_oe,
    output logic [NPINS-1:0]           sec_in,
    input  logic [NPINS-1:0]           pad_in,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe
);

    pin_cfg_t [NPINS-1:0] cfg;
    drive_t   [NPINS-1:0] pri;
    logic     [NPINS-1:0] owner_v, den_v;

    gpio_own_regs #(.NPINS(NPINS), .SEC_MASK(SEC_MASK)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_level (pri_in),
        .cfg       (cfg)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_mux
        logic [NPERIPH-1:0] s_out, s_oe, a_out, a_oe;
        for (genvar p = 0; p < NPERIPH; p++) begin : g_col
            assign s_out[p] = std_pout[p*NPINS+i];
            assign s_oe[p]  = std_poe[p*NPINS+i];
            assign a_out[p] = alt_pout[p*NPINS+i];
            assign a_oe[p]  = alt_poe[p*NPINS+i];
        end
        gpio_own_pinmux #(.NPERIPH(NPERIPH)) u_pinmux (
            .cfg     (cfg[i]),
            .std_out (s_out),
            .std_oe  (s_oe),
            .alt_out (a_out),
            .alt_oe  (a_oe),
            .pri     (pri[i])
        );
        assign owner_v[i] = cfg[i].owner;
        assign den_v[i]   = cfg[i].den;
    end

    gpio_own_route #(.NPINS(NPINS)) u_route (
        .cfg     (cfg),
        .pri     (pri),
        .sec_out (sec_out),
        .sec_oe  (sec_oe),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pri_in  (pri_in),
        .sec_in  (sec_in)
    );

    AST_SEC_VAL: assert property (@(posedge clk) disable iff (rst)
        ((pad_out ^ sec_out) & owner_v) == '0);                           // R2
    AST_SEC_OE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe ^ sec_oe) & owner_v) == '0);                             // R2
    AST_DEN_OE_LOW: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & ~owner_v & ~den_v) == '0);                              // R6
    AST_DEN_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        (pri_in & ~den_v) == '0);                                         // R6
    AST_DEN_READ: assert property (@(posedge clk) disable iff (rst)
        ((pri_in ^ pad_in) & den_v) == '0);                               // R7
    AST_SEC_RAW: assert property (@(posedge clk) disable iff (rst)
        sec_in == pad_in);                                                // R8

endmodule

// File: tb/gpio_own_mux_bench.sv
module gpio_own_mux_bench;

    localparam int NP = 8;
    localparam int NX = 16;
    localparam int PV = NP * NX;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [PV-1:0] std_pout = '0, std_poe = '0, alt_pout = '0, alt_poe = '0;
    logic [NP-1:0] pri_in, sec_in, pad_out, pad_oe;
    logic [NP-1:0] sec_out = '0, sec_oe = '0, pad_in = '0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_own_mux #(.NPINS(NP), .NPERIPH(NX), .SEC_MASK(8'hC0)) u_gpio_own_mux (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .std_pout(std_pout), .std_poe(std_poe), .alt_pout(alt_pout), .alt_poe(alt_poe),
        .pri_in(pri_in), .sec_out(sec_out), .sec_oe(sec_oe), .sec_in(sec_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'd6, v); chk("R1", "owner after reset", v, 32'hC0);
        rd(4'd0, v); chk("R1", "dout after reset", v, 32'h0);
        rd(4'd5, v); chk("R1", "den after reset", v, 32'h0);
        rd(4'd7, v); chk("R1", "std sel after reset", v, 32'h0);
        chk("R1", "pad_oe after reset", {24'h0, pad_oe}, 32'h0);
    endtask

    task automatic t_plain();
        wr(4'd6, 32'h00);
        wr(4'd5, 32'hFF);
        wr(4'd2, 32'h0E);
        wr(4'd0, 32'hA4);
        chk("R3", "plain pad_out", {24'h0, pad_out}, 32'hA4);
        chk("R3", "plain pad_oe", {24'h0, pad_oe}, 32'h0E);
        // write timing: old value holds until the edge
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h3C;
        #1;
        chk("R9", "dout before edge", {24'h0, pad_out}, 32'hA4);
        @(negedge clk);
        bus_wr = 1'b0;
        chk("R9", "dout after edge", {24'h0, pad_out}, 32'h3C);
        wr(4'd0, 32'hA4);
    endtask

    task automatic t_std();
        std_pout[3*NP+0] = 1'b1;
        std_poe[3*NP+0]  = 1'b1;
        wr(4'd7, 32'h0000_0003);
        wr(4'd3, 32'h01);
        chk("R4", "std sel 3 out", {24'h0, pad_out}, 32'hA5);
        chk("R4", "std sel 3 oe", {24'h0, pad_oe}, 32'h0F);
        wr(4'd7, 32'h0000_0002);
        chk("R4", "std sel 2 out", {24'h0, pad_out}, 32'hA4);
        chk("R4", "std sel 2 oe", {24'h0, pad_oe}, 32'h0E);
        wr(4'd7, 32'h0000_0003);
    endtask

    task automatic t_alt();
        wr(4'd8, 32'h0000_0005);
        wr(4'd4, 32'h01);
        chk("R5", "alt ignores std out", {24'h0, pad_out}, 32'hA4);
        chk("R5", "alt ignores std oe", {24'h0, pad_oe}, 32'h0E);
        @(negedge clk);
        alt_pout[5*NP+0] = 1'b1; alt_poe[5*NP+0] = 1'b1;
        #1;
        chk("R5", "alt sel 5 out", {24'h0, pad_out}, 32'hA5);
        chk("R5", "alt sel 5 oe", {24'h0, pad_oe}, 32'h0F);
        @(negedge clk);
        alt_pout[5*NP+0] = 1'b0; alt_pout[3*NP+0] = 1'b1;
        #1;
        chk("R5", "alt unselected periph", {24'h0, pad_out}, 32'hA4);
        alt_pout[5*NP+0] = 1'b1;
        #1;
    endtask

    task automatic t_owner();
        logic [31:0] v;
        @(negedge clk);
        sec_out = 8'h00; sec_oe = 8'h01;
        wr(4'd6, 32'h01);
        rd(4'd6, v); chk("R9", "owner readback", v, 32'h01);
        chk("R2", "sec owns pin0 out", {24'h0, pad_out}, 32'hA4);
        chk("R2", "sec owns pin0 oe", {24'h0, pad_oe}, 32'h0F);
        sec_out = 8'h01; sec_oe = 8'h00;
        #1;
        chk("R2", "sec toggles pin0 out", {24'h0, pad_out}, 32'hA5);
        chk("R2", "sec toggles pin0 oe", {24'h0, pad_oe}, 32'h0E);
        sec_out = 8'h00;
        wr(4'd6, 32'h00);
        chk("R2", "pin0 back to primary", {24'h0, pad_out}, 32'hA5);
    endtask

    task automatic t_den();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 8'hFF;
        wr(4'd5, 32'hFE);
        chk("R6", "den clear oe low", {24'h0, pad_oe}, 32'h0E);
        rd(4'd1, v); chk("R6", "den clear pin level", v, 32'hFE);
        chk("R6", "den clear pri_in", {24'h0, pri_in}, 32'hFE);
    endtask

    task automatic t_secread();
        logic [31:0] v;
        @(negedge clk);
        pad_in = 8'h80;
        wr(4'd6, 32'h80);
        wr(4'd5, 32'hFF);
        rd(4'd1, v); chk("R7", "primary reads sec-owned pin", v, 32'h80);
        chk("R8", "sec_in raw", {24'h0, sec_in}, 32'h80);
        wr(4'd5, 32'h7F);
        rd(4'd1, v); chk("R6", "sec-owned pin den clear", v, 32'h00);
        chk("R8", "sec_in raw with den clear", {24'h0, sec_in}, 32'h80);
        pad_in = 8'h00;
        #1;
        chk("R8", "sec_in follows pad", {24'h0, sec_in}, 32'h00);
    endtask

    task automatic t_unused();
        logic [31:0] v;
        wr(4'hF, 32'hFFFF_FFFF);
        rd(4'hF, v); chk("R9", "unused address reads 0", v, 32'h0);
        wr(4'd1, 32'h0000_0000);
        rd(4'd0, v); chk("R9", "pin-level write ignored", v, 32'hA4);
        rd(4'd5, v); chk("R9", "den unchanged after pin write", v, 32'h7F);
    endtask

    initial begin : watchdog
        #2000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_std();
        t_alt();
        t_owner();
        t_den();
        t_secread();
        t_unused();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule